// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the datapath and control of one DMA channel. Software loads four values through a single-cycle write port: a source pointer, a destination pointer, a unit counter and a control word. Once the channel is enabled, the global master enable is high and a transfer request is present, the channel moves data one unit at a time. Each unit is a read descriptor at the source pointer followed by a write descriptor at the destination pointer. A descriptor carries an address and a size code and is held on a valid/ready handshake toward the memory side.

After each completed unit, the two pointers step independently. Each can stay fixed, count up or count down, and a step moves by the unit size in bytes. The counter drops by one. When the counter is exhausted, the channel sets an end flag, starts nothing further and can raise an interrupt.

Two transmit modes exist. In cycle-steal mode the channel gives up the memory side after every unit and waits for a fresh request. In burst mode it keeps issuing units back to back until the count runs out.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the pointers, the counter and the control word read 0, `mem_valid` is 0 and `irq` is 0.
- R2: The counter keeps only the low 24 bits of a write, so writing 0x1000002 reads back as 2. A loaded 0 stands for 16,777,216 units, so one completed unit from 0 leaves 0xFFFFFF and the end flag clear.
- R3: Each unit issues a read descriptor (`mem_write`=0) at the source pointer, then a write descriptor (`mem_write`=1) at the destination pointer. `mem_size` equals control bits 4:3. A descriptor holds its address and direction until `mem_ready` is seen.
- R4: Control bits 13:12 set the source stepping: 0 fixed, 1 up, 2 down, 3 fixed. A step is the unit size in bytes: size code 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 16 bytes.
- R5: Control bits 15:14 set the destination stepping, with the same encoding and step as R4.
- R6: A unit starts only while control bit 0 (channel enable), `master_en` and `xfer_req` are all 1. Otherwise no descriptor appears.
- R7: Control bit 5 set to 0 selects cycle steal: `mem_valid` drops after every unit, and the next unit needs `xfer_req`. Bit 5 set to 1 selects burst: the next read follows the write at once without `xfer_req`, until the count is used up.
- R8: Control bit 1 (end flag) is set only when the write of the last unit completes. While it is set, no unit starts. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R9: `irq` is high exactly while the end flag and control bit 2 (interrupt enable) are both 1.
- R10: Every completed write descriptor lowers the counter by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wr_data | input | REG_W | Register write data |
| master_en | input | 1 | Global DMA enable |
| xfer_req | input | 1 | Transfer request |
| mem_valid | output | 1 | Descriptor valid |
| mem_ready | input | 1 | Memory side accepts the descriptor |
| mem_write | output | 1 | 0 read, 1 write |
| mem_addr | output | ADDR_W | Descriptor address |
| mem_size | output | 2 | Unit size code |
| src_addr_o | output | ADDR_W | Current source pointer |
| dst_addr_o | output | ADDR_W | Current destination pointer |
| count_o | output | CNT_W | Remaining units |
| ctrl_o | output | REG_W | Control word readback |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach are the pause between two cycle-steal units and the large count that a loaded zero stands for. Neither can be seen if the request stays high or a full run of 2^24 units is awaited. The bench watches read handshakes and withdraws `xfer_req` on the falling edge right after the first one is accepted. The channel is then parked after exactly one unit, where the pointers, the counter (0xFFFFFF from a loaded zero) and the idle handshake can be read. Burst runs use a stalling `mem_ready` pattern, so that descriptor holding and back-to-back units are exercised together.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   localparam logic [1:0] SEL_SRC  = 2'd0;
   localparam logic [1:0] SEL_DST  = 2'd1;
   localparam logic [1:0] SEL_CNT  = 2'd2;
   localparam logic [1:0] SEL_CTRL = 2'd3;

   localparam int CB_EN    = 0;
   localparam int CB_END   = 1;
   localparam int CB_IE    = 2;
   localparam int CB_UNIT  = 3;
   localparam int CB_BURST = 5;
   localparam int CB_SMODE = 12;
   localparam int CB_DMODE = 14;

   typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} seq_state_e;

   typedef struct packed {
      logic [1:0] dst_mode;
      logic [1:0] src_mode;
      logic       burst;
      logic [1:0] unit;
      logic       irq_en;
      logic       done;
      logic       enable;
   } chan_cfg_t;

   function automatic logic [4:0] unit_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd1;
         2'd1:    return 5'd2;
         2'd2:    return 5'd4;
         default: return 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/dma_seq_addr_step.sv
module dma_seq_addr_step
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        mode_i,
   input  logic [1:0]        unit_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int PAD_W = ADDR_W - 5;

   logic [ADDR_W-1:0] delta;
   assign delta = {{PAD_W{1'b0}}, unit_bytes(unit_i)};

   always_comb begin
      case (mode_i)
         2'd1:    addr_o = addr_i + delta;
         2'd2:    addr_o = addr_i - delta;
         default: addr_o = addr_i;
      endcase
   end
endmodule

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
   import dma_seq_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  chan_cfg_t        wr_cfg,
   input  logic             done_set,
   output chan_cfg_t        cfg,
   output logic [REG_W-1:0] ctrl_word
);
   chan_cfg_t cfg_nx;

   always_comb begin
      cfg_nx = cfg;
      if (wr_en) begin
         cfg_nx      = wr_cfg;
         cfg_nx.done = cfg.done & wr_cfg.done;
      end
      if (done_set) cfg_nx.done = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg <= '0;
      else        cfg <= cfg_nx;
   end

   always_comb begin
      ctrl_word                  = '0;
      ctrl_word[CB_EN]           = cfg.enable;
      ctrl_word[CB_END]          = cfg.done;
      ctrl_word[CB_IE]           = cfg.irq_en;
      ctrl_word[CB_UNIT +: 2]    = cfg.unit;
      ctrl_word[CB_BURST]        = cfg.burst;
      ctrl_word[CB_SMODE +: 2]   = cfg.src_mode;
      ctrl_word[CB_DMODE +: 2]   = cfg.dst_mode;
   end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       chain,
   input  logic       last,
   input  logic       mem_ready,
   output seq_state_e state
);
   seq_state_e state_nx;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (start) state_nx = ST_RD;
         ST_RD:   if (mem_ready) state_nx = ST_WR;
         ST_WR:   if (mem_ready) state_nx = (!last && chain) ? ST_RD : ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic              master_en,
   input  logic              xfer_req,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [ADDR_W-1:0] src_addr_o,
   output logic [ADDR_W-1:0] dst_addr_o,
   output logic [CNT_W-1:0]  count_o,
   output logic [REG_W-1:0]  ctrl_o,
   output logic              irq
);
   localparam int N_PTR = 2;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr_w
      $error("dma_chan_seq: ADDR_W must lie in 8..REG_W");
   end
   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("dma_chan_seq: CNT_W must lie in 2..REG_W");
   end
   if (REG_W < 16) begin : g_bad_reg_w
      $error("dma_chan_seq: REG_W must hold the 16 control bits");
   end

   chan_cfg_t  cfg, wr_cfg;
   seq_state_e state;
   logic       run_ok, unit_done, last;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] ptr_q  [N_PTR];
   logic [ADDR_W-1:0] ptr_nx [N_PTR];

   always_comb begin
      wr_cfg.enable   = reg_wr_data[CB_EN];
      wr_cfg.done     = reg_wr_data[CB_END];
      wr_cfg.irq_en   = reg_wr_data[CB_IE];
      wr_cfg.unit     = reg_wr_data[CB_UNIT +: 2];
      wr_cfg.burst    = reg_wr_data[CB_BURST];
      wr_cfg.src_mode = reg_wr_data[CB_SMODE +: 2];
      wr_cfg.dst_mode = reg_wr_data[CB_DMODE +: 2];
   end

   assign run_ok    = cfg.enable & master_en & ~cfg.done;
   assign last      = (cnt_q == CNT_ONE);
   assign unit_done = (state == ST_WR) & mem_ready;

   dma_seq_cfg #(.REG_W(REG_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en && reg_wr_sel == SEL_CTRL),
      .wr_cfg    (wr_cfg),
      .done_set  (unit_done & last),
      .cfg       (cfg),
      .ctrl_word (ctrl_o)
   );

   dma_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (run_ok & xfer_req),
      .chain     (cfg.burst & run_ok),
      .last      (last),
      .mem_ready (mem_ready),
      .state     (state)
   );

   for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
      localparam logic [1:0] MY_SEL = (g == 0) ? SEL_SRC : SEL_DST;

      dma_seq_addr_step #(.ADDR_W(ADDR_W)) u_step (
         .addr_i (ptr_q[g]),
         .mode_i ((g == 0) ? cfg.src_mode : cfg.dst_mode),
         .unit_i (cfg.unit),
         .addr_o (ptr_nx[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                ptr_q[g] <= '0;
         else if (reg_wr_en && reg_wr_sel == MY_SEL) ptr_q[g] <= reg_wr_data[ADDR_W-1:0];
         else if (unit_done)                         ptr_q[g] <= ptr_nx[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   cnt_q <= '0;
      else if (reg_wr_en && reg_wr_sel == SEL_CNT)  cnt_q <= reg_wr_data[CNT_W-1:0];
      else if (unit_done)                           cnt_q <= cnt_q - CNT_ONE;
   end

   assign mem_valid  = (state != ST_IDLE);
   assign mem_write  = (state == ST_WR);
   assign mem_addr   = (state == ST_WR) ? ptr_q[1] : ptr_q[0];
   assign mem_size   = cfg.unit;
   assign src_addr_o = ptr_q[0];
   assign dst_addr_o = ptr_q[1];
   assign count_o    = cnt_q;
   assign irq        = cfg.done & cfg.irq_en;
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 24,
   parameter int REG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic              master_en,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_write,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [CNT_W-1:0]  count_o,
   input logic [REG_W-1:0]  ctrl_o
);
   logic wr_hs, rd_hs;
   assign wr_hs = mem_valid & mem_ready & mem_write;
   assign rd_hs = mem_valid & mem_ready & ~mem_write;

   p_hold_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready && !reg_wr_en) |=>
         (mem_valid && $stable(mem_write) && $stable(mem_addr)));

   p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hs |=> (mem_valid && mem_write));

   p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hs && !reg_wr_en) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

   p_master_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_en && !mem_valid) |=> !mem_valid);

   p_end_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_o[1] && !mem_valid) |=> !mem_valid);

   p_end_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl_o[1]) |-> $past(wr_hs));

   p_steal_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hs && !ctrl_o[5]) |=> !mem_valid);

   p_burst_chain_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hs && ctrl_o[5] && ctrl_o[0] && master_en && !reg_wr_en &&
       count_o != CNT_W'(1)) |=> (mem_valid && !mem_write));
endmodule

bind dma_chan_seq dma_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_chk (.*);

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
   logic        clk = 0;
   logic        rst_n = 0;
   logic        reg_wr_en = 0;
   logic [1:0]  reg_wr_sel = 0;
   logic [31:0] reg_wr_data = 0;
   logic        master_en = 1;
   logic        xfer_req = 0;
   logic        mem_valid, mem_write, irq;
   logic        mem_ready = 1;
   logic [31:0] mem_addr, src_addr_o, dst_addr_o, ctrl_o;
   logic [1:0]  mem_size;
   logic [23:0] count_o;

   typedef struct packed { logic wr; logic [1:0] size; logic [31:0] addr; } desc_t;
   desc_t exp_q[$];
   int n_chk = 0, n_fail = 0, rd_seen = 0, stall_ctr = 0;
   bit stall_en = 0;

   always #4 clk = ~clk;

   dma_chan_seq dut (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] stepped(input logic [31:0] a, input logic [1:0] mode, input logic [1:0] ts);
      logic [31:0] b;
      b = (ts == 0) ? 1 : (ts == 1) ? 2 : (ts == 2) ? 4 : 16;
      if (mode == 1) return a + b;
      if (mode == 2) return a - b;
      return a;
   endfunction

   function automatic logic [31:0] cw(input int dm, input int sm, input int tm, input int ts, input int ie, input int de);
      return (dm << 14) | (sm << 12) | (tm << 5) | (ts << 3) | (ie << 2) | de;
   endfunction

   task automatic push_units(input logic [31:0] s, input logic [31:0] d, input logic [1:0] sm,
                             input logic [1:0] dm, input logic [1:0] ts, input int n);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back('{wr: 1'b0, size: ts, addr: s});
         exp_q.push_back('{wr: 1'b1, size: ts, addr: d});
         s = stepped(s, sm, ts);
         d = stepped(d, dm, ts);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = data;
      @(negedge clk);
      reg_wr_en = 0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
      #3;
   endtask

   task automatic wait_end();
      do settle(1); while (ctrl_o[1] !== 1'b1);
   endtask

   task automatic drop_req_after_read();
      int base;
      base = rd_seen;
      do settle(1); while (rd_seen == base);
      @(negedge clk);
      xfer_req = 0;
   endtask

   // ready pattern
   initial forever begin
      @(negedge clk);
      stall_ctr++;
      mem_ready = stall_en ? (stall_ctr % 3 == 2) : 1'b1;
   end

   // scoreboard monitor (R3)
   initial forever begin
      @(negedge clk);
      #3;
      if (rst_n && mem_valid && mem_ready) begin
         if (!mem_write) rd_seen++;
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R3 unexpected descriptor actual=%h expected=none", {mem_write, mem_size, mem_addr});
         end else begin
            desc_t e;
            e = exp_q.pop_front();
            if ({mem_write, mem_size, mem_addr} !== e) begin
               n_fail++;
               $display("FAIL R3 descriptor actual=%h expected=%h", {mem_write, mem_size, mem_addr}, e);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int base;
      settle(3);
      chk("R1 ctrl in reset", ctrl_o, 0);
      @(negedge clk) rst_n = 1;
      settle(1);
      chk("R1 ctrl", ctrl_o, 0);
      chk("R1 count", count_o, 0);
      chk("R1 src", src_addr_o, 0);
      chk("R1 valid", mem_valid, 0);
      chk("R1 irq", irq, 0);

      // cycle steal, both up, 4-byte unit
      wr_reg(0, 32'h1000);
      wr_reg(1, 32'h2000);
      wr_reg(2, 3);
      push_units(32'h1000, 32'h2000, 1, 1, 2, 3);
      xfer_req = 1;
      wr_reg(3, cw(1, 1, 0, 2, 1, 1));
      wait_end();
      settle(1);
      chk("R4 src up by 4", src_addr_o, 32'h100C);
      chk("R5 dst up by 4", dst_addr_o, 32'h200C);
      chk("R10 count zero", count_o, 0);
      chk("R9 irq on", irq, 1);
      base = rd_seen;
      settle(10);
      chk("R8 no start while end flag", mem_valid, 0);
      chk("R8 no reads while end flag", rd_seen, base);
      wr_reg(3, cw(1, 1, 0, 2, 1, 1) | 2);
      settle(1);
      chk("R8 write 1 keeps flag", ctrl_o[1], 1);
      wr_reg(3, cw(1, 1, 0, 2, 1, 0));
      settle(1);
      chk("R8 write 0 clears flag", ctrl_o[1], 0);
      chk("R9 irq off", irq, 0);
      xfer_req = 0;

      // burst, src down, dst fixed, 16-byte unit, stalls
      wr_reg(0, 32'h8000);
      wr_reg(1, 32'h3000);
      wr_reg(2, 32'h0100_0002);
      settle(1);
      chk("R2 upper count bits dropped", count_o, 2);
      push_units(32'h8000, 32'h3000, 2, 0, 3, 2);
      stall_en = 1;
      wr_reg(3, cw(0, 2, 1, 3, 0, 1));
      @(negedge clk) xfer_req = 1;
      @(negedge clk) xfer_req = 0;
      do settle(1); while (count_o != 1);
      chk("R7 burst continues without request", mem_valid, 1);
      wait_end();
      settle(1);
      chk("R4 src down by 16", src_addr_o, 32'h7FE0);
      chk("R5 dst fixed", dst_addr_o, 32'h3000);
      chk("R9 irq masked", irq, 0);
      chk("R8 flag set", ctrl_o[1], 1);
      wr_reg(3, 0);
      stall_en = 0;

      // cycle steal pause, src mode 3, dst down, byte unit
      wr_reg(0, 32'h40);
      wr_reg(1, 32'h90);
      wr_reg(2, 2);
      push_units(32'h40, 32'h90, 3, 2, 0, 2);
      xfer_req = 1;
      wr_reg(3, cw(2, 3, 0, 0, 1, 1));
      drop_req_after_read();
      settle(8);
      chk("R7 steal released bus", mem_valid, 0);
      chk("R7 steal waits for request", count_o, 1);
      xfer_req = 1;
      wait_end();
      xfer_req = 0;
      settle(1);
      chk("R4 mode 3 fixed", src_addr_o, 32'h40);
      chk("R5 dst down by 1", dst_addr_o, 32'h8E);
      wr_reg(3, 0);

      // master enable gate, 2-byte unit
      master_en = 0;
      wr_reg(0, 32'h500);
      wr_reg(1, 32'h600);
      wr_reg(2, 1);
      push_units(32'h500, 32'h600, 1, 1, 1, 1);
      xfer_req = 1;
      wr_reg(3, cw(1, 1, 0, 1, 0, 1));
      settle(10);
      chk("R6 master off blocks", mem_valid, 0);
      chk("R6 count untouched", count_o, 1);
      master_en = 1;
      wait_end();
      xfer_req = 0;
      settle(1);
      chk("R6 src after start", src_addr_o, 32'h502);
      chk("R6 dst after start", dst_addr_o, 32'h602);
      wr_reg(3, 0);

      // zero count means 2^24
      wr_reg(0, 32'h10);
      wr_reg(1, 32'h20);
      wr_reg(2, 0);
      push_units(32'h10, 32'h20, 1, 1, 2, 1);
      xfer_req = 1;
      wr_reg(3, cw(1, 1, 0, 2, 0, 1));
      drop_req_after_read();
      settle(8);
      chk("R2 zero count wraps", count_o, 24'hFFFFFF);
      chk("R2 no end flag", ctrl_o[1], 0);
      chk("R7 idle after unit", mem_valid, 0);
      wr_reg(3, 0);

      settle(5);
      chk("R3 all descriptors seen", exp_q.size(), 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule